// File: doc/BRIEF.md
# Programmable Down-Count Timer with Prescaler and Periodic Reload

The block is a per-core interval timer. A 32-bit counter is loaded by software and counts down once per prescaler tick. The prescaler divides the bus clock by a power of two taken from a 3-bit code. When the counter reaches zero it adds one to a pending-event counter. In periodic mode it then reloads from the programmed start value. In one-shot mode it stays at zero.

A small table of six interrupt entries sits beside the counter. Entry 0 belongs to the timer and holds its vector, a mask bit and a periodic bit. The consumer raises a request to take one pending event. The request is granted only while entry 0 is unmasked and at least one event is pending. A grant returns the entry's vector and takes one event off the pending count.

A global enable input controls the whole unit. While it is low, every entry is held masked and the pending count is held at zero.

Register selector codes: 0 start value (read/write), 1 live count (read-only), 2 divide code (read/write), 3 pending count (read-only), 4 to 9 entries 0 to 5 (read/write). Any other selector reads as zero.

Top module: `loc_timer`

## Requirements
- R1: After reset, the live count, start value, divide code and pending count read as zero. Every entry reads 0x0001_0000, which is masked only. No grant is given.
- R2: The divide code is built from written bits {3,1,0} as c. The divisor is 2^((c+1) mod 8), so c=111 divides by 1 and c=000 divides by 2. Bit 2 is ignored and reads back as zero. The live count drops by one every divisor clock cycles.
- R3: Writing the start value loads the live count with it, restarts the prescaler phase and clears the pending count.
- R4: A start value of zero leaves the timer idle. The live count reads zero and nothing is added to the pending count.
- R5: In one-shot mode (entry 0 bit 17 clear), after start value N and divisor D, the pending count becomes 1 exactly N*D cycles after the load edge. The live count then stays at zero until the start value is written again.
- R6: In periodic mode (entry 0 bit 17 set), the live count reloads from the start value on each expiry. The pending count rises by one every N*D cycles.
- R7: A request is granted only when entry 0 bit 16 (mask) is clear and the pending count is above zero. A grant outputs entry 0 bits 7:0 as the vector in the same cycle and lowers the pending count by one at the next edge.
- R8: The pending count saturates at 2^PEND_W-1 and does not wrap.
- R9: While the enable is low, bit 16 is held set in all six entries, including entries written during that time, and the pending count is held at zero.
- R10: Entry 0 keeps only bits 7:0, 12, 16 and 17 of a write. Entries 1 to 5 keep only bits 7:0, 10:8, 12 and 16. All other bits read as zero.
- R11: Writing the divide code restarts the prescaler phase, so the next count step comes a full divisor period after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_en | input | 1 | Global software enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register selector for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register selector for reads |
| rd_data | output | 32 | Combinational read data |
| cons_req | input | 1 | Request to consume one pending event |
| cons_ack | output | 1 | Grant of the request in the same cycle |
| cons_vec | output | 8 | Timer vector, valid with the grant |

## Verification
Some rules are checked by assertions on every cycle:
- the live count moves only on a prescaler tick or a load, and stays parked at zero once it gets there;
- a periodic expiry reloads the start value;
- the pending count steps by exactly one per expiry or grant, and holds at its ceiling;
- a grant never occurs while masked or with nothing pending;
- the masks and the pending count are forced while the unit is disabled.

Other properties can only be shown by the bench scenarios:
- the absolute timing of expiries for each of the eight divide codes;
- the delay added by rewriting the divide code mid-count;
- the read-back values of each entry's kept bits.

// File: rtl/loc_timer_pkg.sv
package loc_timer_pkg;
  localparam int DATA_W   = 32;
  localparam int VEC_W    = 8;
  localparam int STAT_BIT = 12;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;
  localparam int SHIFT_W  = 3;
  localparam int PRESC_W  = 7;

  localparam int SEL_INIT     = 0;
  localparam int SEL_CUR      = 1;
  localparam int SEL_DIV      = 2;
  localparam int SEL_PEND     = 3;
  localparam int SEL_ENT_BASE = 4;

  // split code {b3,b1,b0} plus one, wrapping in three bits
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1], cfg[0]};
    return code + 3'd1;
  endfunction

  function automatic logic [PRESC_W-1:0] presc_last(input logic [SHIFT_W-1:0] sh);
    return (PRESC_W'(1) << sh) - PRESC_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] entry_keep(input bit timer_entry);
    logic [DATA_W-1:0] m;
    m = '0;
    m[VEC_W-1:0] = '1;
    m[STAT_BIT]  = 1'b1;
    m[MASK_BIT]  = 1'b1;
    if (timer_entry) m[PER_BIT] = 1'b1;
    else             m[10:8]    = 3'b111;
    return m;
  endfunction
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import loc_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRESC_W-1:0] phase;

  assign tick = (phase == presc_last(shift));

  always_ff @(posedge clk) begin
    if (!rst_n)                phase <= '0;
    else if (restart || tick)  phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  // R11: after a restart the phase is fresh; a tick follows only for divide-by-1
  a_r11_phase_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (tick == (shift == '0)));
endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         periodic,
  output logic [W-1:0] cur,
  output logic [W-1:0] init_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  assign expire = tick && !load && (cur == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      init_q <= '0;
    end else if (load) begin
      cur    <= load_val;
      init_q <= load_val;
    end else if (tick && cur != '0) begin
      if (cur == ONE) cur <= periodic ? init_q : '0;
      else            cur <= cur - 1'b1;
    end
  end

  a_r2_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur));
  a_r5_parked_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && !load) |=> cur == '0);
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val));
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && periodic) |=> cur == init_q);
endmodule

// File: rtl/lt_pending.sv
module lt_pending #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         req,
  input  logic         gate,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         ack
);
  localparam logic [W-1:0] TOP = '1;

  assign ack = req && gate && (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                                cnt <= '0;
    else if (clr)                              cnt <= '0;
    else if (inc && !ack && cnt != TOP)        cnt <= cnt + 1'b1;
    else if (!inc && ack)                      cnt <= cnt - 1'b1;
  end

  a_r8_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == TOP && !ack && !clr) |=> cnt == TOP);
  a_r7_one_per_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !inc && !clr) |=> cnt == $past(cnt) - 1'b1);
  a_r6_one_per_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ack && !clr && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/lt_entry_bank.sv
module lt_entry_bank
  import loc_timer_pkg::*;
#(
  parameter int N = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic [N-1:0]                wr_hit,
  input  logic [DATA_W-1:0]           wr_val,
  output logic [N-1:0][DATA_W-1:0]    ent
);
  localparam logic [DATA_W-1:0] MASK_ONE = DATA_W'(1) << MASK_BIT;

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam logic [DATA_W-1:0] KEEP = entry_keep(g == 0);
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (!rst_n)          q <= MASK_ONE;
      else if (!en)        q <= (wr_hit[g] ? (wr_val & KEEP) : q) | MASK_ONE;
      else if (wr_hit[g])  q <= wr_val & KEEP;
    end

    assign ent[g] = q;

    a_r9_forced_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> q[MASK_BIT]);
    a_r10_kept_bits: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[g] |=> (q & ~KEEP) == '0);
  end
endmodule

// File: rtl/loc_timer.sv
module loc_timer
  import loc_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PEND_W = 8,
  parameter int N_ENT  = 6,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_en,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cons_req,
  output logic              cons_ack,
  output logic [VEC_W-1:0]  cons_vec
);
  logic                          init_wr, div_wr, tick, expire, periodic, unmasked, pend_clr;
  logic [3:0]                    div_q;
  logic [SHIFT_W-1:0]            shift;
  logic [CNT_W-1:0]              cur, init_q;
  logic [PEND_W-1:0]             pend;
  logic [N_ENT-1:0]              ent_hit;
  logic [N_ENT-1:0][DATA_W-1:0]  ent;

  assign init_wr = wr_en && (wr_sel == SEL_W'(SEL_INIT));
  assign div_wr  = wr_en && (wr_sel == SEL_W'(SEL_DIV));

  for (genvar g = 0; g < N_ENT; g++) begin : g_hit
    assign ent_hit[g] = wr_en && (wr_sel == SEL_W'(SEL_ENT_BASE + g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (div_wr) div_q <= {wr_data[3], 1'b0, wr_data[1:0]};
  end

  assign shift    = div_shift(div_q);
  assign periodic = ent[0][PER_BIT];
  assign unmasked = !ent[0][MASK_BIT];
  assign pend_clr = init_wr || !sw_en;
  assign cons_vec = ent[0][VEC_W-1:0];

  lt_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .restart(init_wr || div_wr), .shift(shift), .tick(tick)
  );

  lt_downcount #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(init_wr), .load_val(wr_data[CNT_W-1:0]),
    .tick(tick), .periodic(periodic), .cur(cur), .init_q(init_q), .expire(expire)
  );

  lt_pending #(.W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(expire), .req(cons_req), .gate(unmasked),
    .clr(pend_clr), .cnt(pend), .ack(cons_ack)
  );

  lt_entry_bank #(.N(N_ENT)) u_bank (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .wr_hit(ent_hit), .wr_val(wr_data), .ent(ent)
  );

  always_comb begin
    rd_data = '0;
    if (rd_sel == SEL_W'(SEL_INIT))      rd_data = DATA_W'(init_q);
    else if (rd_sel == SEL_W'(SEL_CUR))  rd_data = DATA_W'(cur);
    else if (rd_sel == SEL_W'(SEL_DIV))  rd_data = DATA_W'(div_q);
    else if (rd_sel == SEL_W'(SEL_PEND)) rd_data = DATA_W'(pend);
    else begin
      for (int i = 0; i < N_ENT; i++)
        if (rd_sel == SEL_W'(SEL_ENT_BASE + i)) rd_data = ent[i];
    end
  end

  a_r7_grant_needs_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    cons_ack |-> (!ent[0][MASK_BIT] && pend != '0));
  a_r9_pend_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> pend == '0);
  a_r4_idle_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (init_wr && wr_data[CNT_W-1:0] == '0) |=> !expire);
endmodule

// File: tb/loc_timer_tb_top.sv
module loc_timer_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, sw_en = 1, wr_en = 0, cons_req = 0;
  logic [3:0]  wr_sel = 0, rd_sel = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        cons_ack;
  logic [7:0]  cons_vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  loc_timer dut_i (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .cons_req(cons_req),
    .cons_ack(cons_ack), .cons_vec(cons_vec)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_reg(input logic [3:0] s, input logic [31:0] exp, input string tag);
    rd_sel = s;
    #1;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    expect_reg(4'd0, 32'h0, "R1 start");
    expect_reg(4'd1, 32'h0, "R1 live");
    expect_reg(4'd2, 32'h0, "R1 divide");
    expect_reg(4'd3, 32'h0, "R1 pending");
    for (int i = 0; i < 6; i++) expect_reg(4'(4 + i), 32'h0001_0000, "R1 entry");
    cons_req = 1; #1;
    chk(cons_ack === 1'b0, "R1 grant", 32'(cons_ack), 32'h0);
    cons_req = 0;

    // R10 kept bits
    wr(4'd4, 32'hFFFF_FFFF);
    expect_reg(4'd4, 32'h0003_10FF, "R10 timer entry");
    wr(4'd5, 32'hFFFF_FFFF);
    expect_reg(4'd5, 32'h0001_17FF, "R10 other entry");
    wr(4'd5, 32'h0001_0000);

    // R2 / R5 sweep of all divide codes, one-shot, start value 3
    wr(4'd4, 32'h0001_0041);
    for (int c = 0; c < 8; c++) begin
      int d;
      logic [2:0] cb;
      cb = 3'(c);
      d = 1 << ((c + 1) % 8);
      wr(4'd2, {28'h0, cb[2], 1'b1, cb[1], cb[0]});
      expect_reg(4'd2, {28'h0, cb[2], 1'b0, cb[1], cb[0]}, "R2 divide readback");
      wr(4'd0, 32'd3);
      step(d);
      expect_reg(4'd1, 32'd2, "R2 first step");
      step(2 * d - 1);
      expect_reg(4'd3, 32'd0, "R5 not yet expired");
      expect_reg(4'd1, 32'd1, "R2 last step");
      step(1);
      expect_reg(4'd3, 32'd1, "R5 expired");
      expect_reg(4'd1, 32'd0, "R5 at zero");
      step(5);
      expect_reg(4'd1, 32'd0, "R5 stays zero");
    end

    // R4 zero start value
    wr(4'd0, 32'd0);
    expect_reg(4'd1, 32'd0, "R4 live zero");
    step(10);
    expect_reg(4'd1, 32'd0, "R4 still zero");
    expect_reg(4'd3, 32'd0, "R4 no pending");

    // R11 divide rewrite restarts phase (D=4, N=1)
    wr(4'd2, 32'h1);
    wr(4'd0, 32'd1);
    wr(4'd2, 32'h1);
    step(3);
    expect_reg(4'd3, 32'd0, "R11 delayed");
    expect_reg(4'd1, 32'd1, "R11 still one");
    step(1);
    expect_reg(4'd3, 32'd1, "R11 expiry");

    // R6 periodic, D=1, N=5
    wr(4'd4, 32'h0003_0041);
    wr(4'd2, 32'hB);
    wr(4'd0, 32'd5);
    step(4);
    expect_reg(4'd1, 32'd1, "R6 before expiry");
    expect_reg(4'd3, 32'd0, "R6 none yet");
    step(1);
    expect_reg(4'd3, 32'd1, "R6 first expiry");
    expect_reg(4'd1, 32'd5, "R6 reloaded");
    step(1);
    expect_reg(4'd1, 32'd4, "R6 counting again");
    step(4);
    expect_reg(4'd3, 32'd2, "R6 second expiry");

    // R3 restart clears pending
    wr(4'd0, 32'd7);
    expect_reg(4'd3, 32'd0, "R3 pending cleared");
    expect_reg(4'd1, 32'd7, "R3 loaded");
    step(2);
    expect_reg(4'd1, 32'd5, "R3 counting");

    // R8 saturation: expiry every cycle
    wr(4'd0, 32'd1);
    step(300);
    expect_reg(4'd3, 32'd255, "R8 saturated");

    // R9 disable
    sw_en = 0;
    step(1);
    expect_reg(4'd3, 32'd0, "R9 pending zero");
    for (int i = 0; i < 6; i++) begin
      rd_sel = 4'(4 + i); #1;
      chk(rd_data[16] === 1'b1, "R9 entry masked", rd_data, rd_data | 32'h0001_0000);
    end
    wr(4'd4, 32'h0000_0041);
    expect_reg(4'd4, 32'h0001_0041, "R9 write forced masked");
    expect_reg(4'd3, 32'd0, "R9 pending held");
    sw_en = 1;
    wr(4'd4, 32'h0000_0041);
    expect_reg(4'd4, 32'h0000_0041, "R9 unmask after enable");

    // R7 consume handshake, one-shot N=2 D=1
    wr(4'd4, 32'h0001_0041);
    wr(4'd0, 32'd2);
    step(2);
    expect_reg(4'd3, 32'd1, "R7 one pending");
    cons_req = 1; #1;
    chk(cons_ack === 1'b0, "R7 masked no grant", 32'(cons_ack), 32'h0);
    step(1);
    cons_req = 0;
    expect_reg(4'd3, 32'd1, "R7 masked keeps pending");
    wr(4'd4, 32'h0000_0041);
    cons_req = 1; #1;
    chk(cons_ack === 1'b1, "R7 grant", 32'(cons_ack), 32'h1);
    chk(cons_vec === 8'h41, "R7 vector", 32'(cons_vec), 32'h41);
    step(1);
    #1;
    chk(cons_ack === 1'b0, "R7 nothing left", 32'(cons_ack), 32'h0);
    cons_req = 0;
    expect_reg(4'd3, 32'd0, "R7 decremented");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule